// File: doc/BRIEF.md
# Storage host control and status register file

This block is the software-visible register slice of a parallel storage-device host controller. A 32-bit bus master reads and writes three registers through a simple strobe/acknowledge slave port. The control register drives the active-low device reset line, the core enable and the ready-handshake enable. The timing register carries four 8-bit PIO timing counts that are passed straight out to the transfer engine. The status register reports a fixed version code and a sticky interrupt-pending flag.

The device interrupt request is asynchronous to the bus clock. It passes through a two-flop synchronizer, and its rising edge sets the pending flag. The flag stays set until software writes a 0 to it, so polling reads never lose an interrupt. Address decoding of the device's own registers and the transfer engine itself live elsewhere.

Top module: `hcs_regfile`

## Requirements
- R1: After reset, the control and timing registers read 0, all timing outputs, `core_en` and `iordy_en` are 0, `dev_rst_n` is 1, and the status register reads 0x1000_0000.
- R2: While control bit 0 is 1, `dev_rst_n` is driven low; once that bit is written back to 0, `dev_rst_n` returns high in the cycle after the write.
- R3: Control bit 7 drives `core_en` and control bit 1 drives `iordy_en`; the control register reads back exactly what was written (for example 0x80 and 0x82).
- R4: Status bits [31:28] always read the version constant (default 1) and bits [27:1] read 0; writes do not change them.
- R5: A rising edge on `dev_irq` sets status bit 0 no later than the third clock edge after the edge, also for a pulse a few clocks long; a level that stays high does not set the bit again after it has been cleared.
- R6: Reads of the status register leave bit 0 unchanged.
- R7: A write to the status register with byte enable 0 set and data bit 0 equal to 0 clears status bit 0; writing 1 there leaves it unchanged.
- R8: If a synchronized rising edge and a clearing write fall in the same clock, bit 0 ends up set.
- R9: The timing register holds the end-of-cycle count in [31:24], the hold count in [23:16], the active-strobe count in [15:8] and the setup count in [7:0]; it reads back as written, and each field appears on its own output.
- R10: Each byte of a written register changes only when its byte enable (`bus_be[i]` for bits [8i+7:8i]) is 1.
- R11: Byte offsets 0x0, 0x4 and 0x8 select control, status and timing; offset 0xC reads 0, and writes to it change no register.
- R12: `bus_ack` rises the clock after `bus_sel` is first seen and stays high for exactly one cycle; read data is valid while `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [ADDR_W-1:2] select the register |
| bus_be | input | 4 | Byte enables for the write lanes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle acknowledge |
| dev_irq | input | 1 | Asynchronous device interrupt request |
| dev_rst_n | output | 1 | Active-low device reset |
| core_en | output | 1 | Controller enable |
| iordy_en | output | 1 | Enable for the device ready handshake |
| t_end_cyc | output | 8 | End-of-cycle timing count |
| t_hold | output | 8 | Hold timing count |
| t_active | output | 8 | Active-strobe timing count |
| t_setup | output | 8 | Setup timing count |

## Verification
The bench builds the block with its defaults: a 4-bit byte address, which covers all three registers plus one unmapped offset, and a version code of 1. With these values every byte lane can be written alone, and the unmapped offset 0xC is reachable. The interrupt is raised at a chosen falling edge so that a clearing write can be placed on the exact clock where the synchronized edge lands. That exposes the priority between set and clear.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

  typedef struct packed {
    logic [7:0] end_cyc;
    logic [7:0] hold;
    logic [7:0] active;
    logic [7:0] setup;
  } pio_timing_t;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_TIME = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Status word: version code on top, pending flag at the bottom.
  function automatic logic [31:0] stat_word(input logic [3:0] ver, input logic pend);
    return {ver, 27'd0, pend};
  endfunction

  // Split a 32-bit timing word into its four counts.
  function automatic pio_timing_t unpack_timing(input logic [31:0] w);
    pio_timing_t t;
    t = w;
    return t;
  endfunction

endpackage

// File: rtl/hcs_wreg.sv
module hcs_wreg #(
  parameter int W = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [W/8-1:0] be,
  input  logic [W-1:0]   wd,
  output logic [W-1:0]   q
);
  localparam int NB = W / 8;

  logic [7:0] lane_q [NB];

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q[b] <= RST[b*8 +: 8];
      else if (wr_en && be[b])
        lane_q[b] <= wd[b*8 +: 8];
    end

    // R10: a lane without its enable keeps its value
    a_r10_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && be[b]) |=> $stable(lane_q[b]));
  end

  always_comb begin
    for (int b = 0; b < NB; b++) q[b*8 +: 8] = lane_q[b];
  end
endmodule

// File: rtl/hcs_irq_capture.sv
module hcs_irq_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_async,
  input  logic clr_req,
  output logic set_evt,
  output logic pend
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= irq_async;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign set_evt = s2 && !s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (set_evt) pend <= 1'b1;
    else if (clr_req) pend <= 1'b0;
  end

  // R5: a synchronized edge always lands in the flag
  a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> pend);
  // R6: without a clear the flag never drops
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr_req) |=> pend);
  // R8: set beats a simultaneous clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && clr_req) |=> pend);
  // R7: a clear without an edge empties the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !pend);
endmodule

// File: rtl/hcs_regfile.sv
module hcs_regfile #(
  parameter int         ADDR_W  = 4,
  parameter logic [3:0] VERSION = 4'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ack,
  input  logic              dev_irq,
  output logic              dev_rst_n,
  output logic              core_en,
  output logic              iordy_en,
  output logic [7:0]        t_end_cyc,
  output logic [7:0]        t_hold,
  output logic [7:0]        t_active,
  output logic [7:0]        t_setup
);
  import hcs_pkg::*;

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  reg_sel_e         rsel;
  logic             acc_go, wr_go, rd_go;
  logic             wr_ctrl, wr_stat, wr_time;
  logic             clr_req, set_evt, irq_pend;
  logic [31:0]      ctrl_q, time_q, rd_mux;
  pio_timing_t      tim;

  assign idx    = bus_addr[ADDR_W-1:2];
  assign acc_go = bus_sel && !bus_ack;
  assign wr_go  = acc_go && bus_we;
  assign rd_go  = acc_go && !bus_we;

  always_comb begin
    if      (idx == IDX_W'(0)) rsel = SEL_CTRL;
    else if (idx == IDX_W'(1)) rsel = SEL_STAT;
    else if (idx == IDX_W'(2)) rsel = SEL_TIME;
    else                       rsel = SEL_NONE;
  end

  assign wr_ctrl = wr_go && (rsel == SEL_CTRL);
  assign wr_stat = wr_go && (rsel == SEL_STAT);
  assign wr_time = wr_go && (rsel == SEL_TIME);
  assign clr_req = wr_stat && bus_be[0] && !bus_wdata[0];

  hcs_wreg #(.W(32), .RST('0)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .be(bus_be),
    .wd(bus_wdata), .q(ctrl_q));

  hcs_wreg #(.W(32), .RST('0)) u_time (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_time), .be(bus_be),
    .wd(bus_wdata), .q(time_q));

  hcs_irq_capture u_irq (
    .clk(clk), .rst_n(rst_n), .irq_async(dev_irq), .clr_req(clr_req),
    .set_evt(set_evt), .pend(irq_pend));

  always_comb begin
    unique case (rsel)
      SEL_CTRL: rd_mux = ctrl_q;
      SEL_STAT: rd_mux = stat_word(VERSION, irq_pend);
      SEL_TIME: rd_mux = time_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= acc_go;
      bus_rdata <= rd_go ? rd_mux : '0;
    end
  end

  assign dev_rst_n = !ctrl_q[0];
  assign iordy_en  = ctrl_q[1];
  assign core_en   = ctrl_q[7];

  assign tim       = unpack_timing(time_q);
  assign t_end_cyc = tim.end_cyc;
  assign t_hold    = tim.hold;
  assign t_active  = tim.active;
  assign t_setup   = tim.setup;

  // R12: acknowledge follows a new strobe and lasts one cycle
  a_r12_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go |=> bus_ack);
  a_r12_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);
  // R2: setting control bit 0 pulls the device reset low
  a_r2_rst_assert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_be[0] && bus_wdata[0]) |=> !dev_rst_n);
  a_r2_rst_release: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_be[0] && !bus_wdata[0]) |=> dev_rst_n);
  // R4: a status read always carries the version code
  a_r4_version: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && rsel == SEL_STAT) |=> (bus_rdata[31:28] == VERSION && bus_rdata[27:1] == '0));
  // R11: unmapped offset returns zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && rsel == SEL_NONE) |=> (bus_rdata == '0));
endmodule

// File: tb/tb_hcs_regfile.sv
`timescale 1ns/1ps
module tb_hcs_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0, bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic        dev_irq = 1'b0;
  logic        dev_rst_n, core_en, iordy_en;
  logic [7:0]  t_end_cyc, t_hold, t_active, t_setup;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  hcs_regfile dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .dev_irq(dev_irq),
    .dev_rst_n(dev_rst_n), .core_en(core_en), .iordy_en(iordy_en),
    .t_end_cyc(t_end_cyc), .t_hold(t_hold), .t_active(t_active),
    .t_setup(t_setup));

  // Vector: {addr[3:0], be[3:0], wdata[31:0], expected readback[31:0]}
  localparam int NV = 10;
  localparam logic [71:0] VEC [NV] = '{
    {4'h0, 4'hF, 32'h0000_0080, 32'h0000_0080},  // R3
    {4'h0, 4'hF, 32'h0000_0082, 32'h0000_0082},  // R3
    {4'h8, 4'hF, 32'h1802_1C04, 32'h1802_1C04},  // R9
    {4'h8, 4'hF, 32'h0501_1C02, 32'h0501_1C02},  // R9
    {4'h8, 4'h2, 32'hFFFF_AAFF, 32'h0501_AA02},  // R10
    {4'h8, 4'h8, 32'h0700_0000, 32'h0701_AA02},  // R10
    {4'hC, 4'hF, 32'hDEAD_BEEF, 32'h0000_0000},  // R11
    {4'h4, 4'hF, 32'hFFFF_FFFE, 32'h1000_0000},  // R4
    {4'h0, 4'h4, 32'h00FF_0000, 32'h00FF_0082},  // R10
    {4'h0, 4'hF, 32'h0000_0082, 32'h0000_0082}   // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Starts at a falling edge and returns at a falling edge.
  task automatic xfer(input logic we, input logic [3:0] a, input logic [3:0] be,
                      input logic [31:0] wd, output logic [31:0] rd);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
    @(negedge clk);
    check("R12 ack high", {31'd0, bus_ack}, 32'd1);
    rd = bus_rdata;
    bus_sel = 1'b0; bus_we = 1'b0;
    @(negedge clk);
    check("R12 ack single", {31'd0, bus_ack}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 dev_rst_n", {31'd0, dev_rst_n}, 32'd1);
    check("R1 enables", {30'd0, core_en, iordy_en}, 32'd0);
    check("R1 timing outs", {t_end_cyc, t_hold, t_active, t_setup}, 32'd0);
    xfer(1'b0, 4'h0, 4'hF, 32'd0, rd); check("R1 ctrl", rd, 32'h0);
    xfer(1'b0, 4'h4, 4'hF, 32'd0, rd); check("R1 stat", rd, 32'h1000_0000);
    xfer(1'b0, 4'h8, 4'hF, 32'd0, rd); check("R1 timing", rd, 32'h0);

    // Table walk: write then read back
    for (int i = 0; i < NV; i++) begin
      logic [71:0] v;
      v = VEC[i];
      xfer(1'b1, v[71:68], v[67:64], v[63:32], rd);
      xfer(1'b0, v[71:68], 4'hF, 32'd0, rd);
      check("R3/R4/R9/R10/R11 readback", rd, v[31:0]);
    end

    // R3 enable outputs with 0x82 in control
    check("R3 core_en/iordy_en", {30'd0, core_en, iordy_en}, 32'd3);
    // R9 timing outputs with 0x0701AA02
    check("R9 t_end_cyc", {24'd0, t_end_cyc}, 32'h07);
    check("R9 t_hold", {24'd0, t_hold}, 32'h01);
    check("R9 t_active", {24'd0, t_active}, 32'hAA);
    check("R9 t_setup", {24'd0, t_setup}, 32'h02);

    // R2 device reset control
    xfer(1'b1, 4'h0, 4'hF, 32'h0000_0081, rd);
    for (int k = 0; k < 5; k++) begin
      check("R2 reset held low", {31'd0, dev_rst_n}, 32'd0);
      @(negedge clk);
    end
    xfer(1'b1, 4'h0, 4'hF, 32'h0000_0080, rd);
    check("R2 reset released", {31'd0, dev_rst_n}, 32'd1);
    xfer(1'b0, 4'h0, 4'hF, 32'd0, rd); check("R2 ctrl readback", rd, 32'h80);

    // R5 short pulse sets pending
    dev_irq = 1'b1;
    repeat (4) @(negedge clk);
    dev_irq = 1'b0;
    repeat (4) @(negedge clk);
    xfer(1'b0, 4'h4, 4'hF, 32'd0, rd); check("R5 pulse sets", rd, 32'h1000_0001);
    // R6 stays set over reads
    xfer(1'b0, 4'h4, 4'hF, 32'd0, rd); check("R6 sticky 1", rd, 32'h1000_0001);
    repeat (5) @(negedge clk);
    xfer(1'b0, 4'h4, 4'hF, 32'd0, rd); check("R6 sticky 2", rd, 32'h1000_0001);
    // R7 writing 1 keeps, byte lane 0 off keeps, writing 0 clears
    xfer(1'b1, 4'h4, 4'hF, 32'h0000_0001, rd);
    xfer(1'b0, 4'h4, 4'hF, 32'd0, rd); check("R7 write 1 keeps", rd, 32'h1000_0001);
    xfer(1'b1, 4'h4, 4'hE, 32'h0000_0000, rd);
    xfer(1'b0, 4'h4, 4'hF, 32'd0, rd); check("R7 be0 off keeps", rd, 32'h1000_0001);
    xfer(1'b1, 4'h4, 4'hF, 32'h0000_0000, rd);
    xfer(1'b0, 4'h4, 4'hF, 32'd0, rd); check("R7 cleared", rd, 32'h1000_0000);
    xfer(1'b0, 4'h4, 4'hF, 32'd0, rd); check("R7 stays clear", rd, 32'h1000_0000);

    // R8 edge reaches the flag on the third edge; place the clear there
    dev_irq = 1'b1;
    repeat (2) @(negedge clk);
    xfer(1'b1, 4'h4, 4'hF, 32'h0000_0000, rd);
    xfer(1'b0, 4'h4, 4'hF, 32'd0, rd); check("R8 set wins", rd, 32'h1000_0001);
    // R5 a held level does not set again once cleared
    xfer(1'b1, 4'h4, 4'hF, 32'h0000_0000, rd);
    repeat (6) @(negedge clk);
    xfer(1'b0, 4'h4, 4'hF, 32'd0, rd); check("R5 level no reset", rd, 32'h1000_0000);
    dev_irq = 1'b0;

    // R11 unmapped write left every register alone
    xfer(1'b1, 4'hC, 4'hF, 32'hFFFF_FFFF, rd);
    xfer(1'b0, 4'h0, 4'hF, 32'd0, rd); check("R11 ctrl intact", rd, 32'h80);
    xfer(1'b0, 4'h8, 4'hF, 32'd0, rd); check("R11 timing intact", rd, 32'h0701_AA02);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule